// File: doc/BRIEF.md
# Unaligned Quad-Word Load Aligner

This block sits between a memory read port that returns aligned quad words (four 32-bit words, 128 bits) and a register destination that wants four consecutive words starting at any word address. A plain load path accepts only quad-aligned addresses. With this block in the path, a stream of sequential loads can begin at any word offset inside a quad, which suits sliding-window access such as filter tap data.

The block captures the word offset (address bits [1:0]) when a stream starts and keeps it until a flush. With a nonzero offset, the first aligned fetch only fills the buffer. Every later fetch is joined with the quad kept from the previous fetch, and the pair is shifted so that the output begins at the chosen word. With offset zero, each fetch is passed straight through and no filling fetch is needed. Both sides use a valid/ready handshake, and a registered output stage holds its quad while the consumer stalls. A flush empties the buffer, so the next fetch starts a new stream.

Top module: `qalign_buf`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1, and the buffer holds no stream.
- R2: The word offset is taken from in_offset on the first fetch accepted after reset or flush. Values on in_offset during later fetches of the same stream have no effect on out_data.
- R3: With a nonzero captured offset, the first accepted fetch of a stream produces no output: out_valid is 0 in the following cycle.
- R4: With offset k in 1..3, the output for a fetch is defined as follows. Output word j (bits [32j+31:32j]) is word j+k of the previous fetched quad when j+k < 4. Otherwise it is word j+k-4 of the current quad.
- R5: With offset 0, every accepted fetch, including the first one, appears unchanged on out_data with out_valid high in the cycle after acceptance.
- R6: Apart from the filling fetch of R3, each accepted fetch yields exactly one output quad, valid in the cycle after acceptance. out_valid is never high without such a fetch.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0, and out_valid and out_data hold in the next cycle. No fetched data is lost.
- R8: An asserted flush discards any output quad being held and the kept quad. In the next cycle out_valid is 0, and the next accepted fetch starts a new stream with a newly captured offset.
- R9: While flush is 1, in_ready is 0, so no fetch is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the buffer and drops the held output |
| in_valid | input | 1 | Fetched aligned quad is present |
| in_ready | output | 1 | Block accepts the fetched quad this cycle |
| in_data | input | 128 | Aligned quad; word i in bits [32i+31:32i] |
| in_offset | input | 2 | Word offset of the stream, used on its first fetch |
| out_valid | output | 1 | Shifted quad is available |
| out_ready | input | 1 | Consumer takes the shifted quad |
| out_data | output | 128 | Four consecutive words from the requested offset |

## Verification
In one cycle the consumer can drain the held output while a new fetch is accepted and merged with the kept quad. A flush can also arrive while an output is held and a fetch is offered. The random phase provokes both cases. It toggles out_ready and in_valid independently, raises flush now and then with in_valid high, and changes in_offset on every beat. Each cycle, a bench model judges them. The model keeps its own kept quad, offset and pending output. It checks in_ready, out_valid and out_data against the model, so a lost, duplicated or wrongly merged quad shows up as a mismatch.

// File: rtl/qalign_pkg.sv
package qalign_pkg;

  // Fill state of the stream buffer
  typedef enum logic {
    FILL_EMPTY  = 1'b0,
    FILL_PRIMED = 1'b1
  } fill_e;

  // Position of output lane j inside the {newer, older} pair for offset k
  function automatic int unsigned pair_lane(input int unsigned j, input int unsigned k);
    return j + k;
  endfunction

endpackage

// File: rtl/qalign_ctl.sv
module qalign_ctl
  import qalign_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             accept,
  input  logic [OFF_W-1:0] in_offset,
  output logic             primed,
  output logic [OFF_W-1:0] cur_off,
  output logic             emit
);

  fill_e            fill_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= FILL_EMPTY;
      off_q  <= '0;
    end else if (flush) begin
      fill_q <= FILL_EMPTY;
    end else if (accept && fill_q == FILL_EMPTY) begin
      fill_q <= FILL_PRIMED;
      off_q  <= in_offset;
    end
  end

  assign primed  = (fill_q == FILL_PRIMED);
  assign cur_off = primed ? off_q : in_offset;
  // A fetch yields output unless it is the filling fetch of a nonzero offset
  assign emit    = accept && (primed || in_offset == '0);

  // The captured offset is locked for the whole stream
  assert_offset_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !flush |=> primed && $stable(off_q));

  // A flush returns the buffer to empty
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !primed);

endmodule

// File: rtl/qalign_hold.sv
module qalign_hold #(
  parameter int QW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [QW-1:0] in_data,
  output logic [QW-1:0] older
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      older <= '0;
    else if (accept) older <= in_data;
  end

  // The kept quad only changes on an accepted fetch
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(older));

endmodule

// File: rtl/qalign_shift.sv
module qalign_shift
  import qalign_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANES  = 4,
  parameter int OFF_W  = 2
) (
  input  logic [LANES*WORD_W-1:0] older,
  input  logic [LANES*WORD_W-1:0] newer,
  input  logic [OFF_W-1:0]        off,
  output logic [LANES*WORD_W-1:0] merged
);

  localparam int QW = LANES * WORD_W;

  logic [2*QW-1:0] pair;
  assign pair = {newer, older};

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      int unsigned src;
      src = pair_lane(j, 32'(off));
      if (off == '0) merged[j*WORD_W +: WORD_W] = newer[j*WORD_W +: WORD_W];
      else           merged[j*WORD_W +: WORD_W] = pair[src*WORD_W +: WORD_W];
    end
  end

  // Top lane always comes from the newer quad when an offset is in force
  always_comb begin
    if (off != '0)
      assert_top_lane_new_R4: assert (merged[QW-1 -: WORD_W] ==
                                       newer[(32'(off)-1)*WORD_W +: WORD_W]);
  end

endmodule

// File: rtl/qalign_outreg.sv
module qalign_outreg #(
  parameter int QW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          load,
  input  logic [QW-1:0] load_data,
  input  logic          drain,
  output logic          vld,
  output logic [QW-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      data <= '0;
    end else if (flush) begin
      vld  <= 1'b0;
    end else if (load) begin
      vld  <= 1'b1;
      data <= load_data;
    end else if (drain) begin
      vld  <= 1'b0;
    end
  end

  // Stalled output keeps its quad
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vld && !drain && !flush |=> vld && $stable(data));

  // A held quad is dropped by flush
  assert_flush_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !vld);

endmodule

// File: rtl/qalign_buf.sv
module qalign_buf #(
  parameter int WORD_W = 32,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*WORD_W-1:0] in_data,
  input  logic [$clog2(LANES)-1:0] in_offset,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*WORD_W-1:0] out_data
);

  localparam int QW    = LANES * WORD_W;
  localparam int OFF_W = $clog2(LANES);

  // Named internal events
  logic             accept;
  logic             emit;
  logic             prime_only;
  logic             primed;
  logic [OFF_W-1:0] cur_off;
  logic [QW-1:0]    older;
  logic [QW-1:0]    merged;

  assign in_ready   = !flush && (!out_valid || out_ready);
  assign accept     = in_valid && in_ready;
  assign prime_only = accept && !emit;

  qalign_ctl #(.OFF_W(OFF_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .accept   (accept),
    .in_offset(in_offset),
    .primed   (primed),
    .cur_off  (cur_off),
    .emit     (emit)
  );

  qalign_hold #(.QW(QW)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .in_data(in_data),
    .older  (older)
  );

  qalign_shift #(.WORD_W(WORD_W), .LANES(LANES), .OFF_W(OFF_W)) u_shift (
    .older (older),
    .newer (in_data),
    .off   (cur_off),
    .merged(merged)
  );

  qalign_outreg #(.QW(QW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .load     (emit),
    .load_data(merged),
    .drain    (out_ready),
    .vld      (out_valid),
    .data     (out_data)
  );

  // Filling fetch gives no output
  assert_prime_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prime_only |=> !out_valid);

  // Offset zero passes the fetch straight through
  assert_zero_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cur_off == '0 |=> out_valid && out_data == $past(in_data));

  // Every emitting fetch shows up next cycle
  assert_emit_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> out_valid);

  // A stalled consumer blocks new fetches
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !accept);

  // Flush blocks acceptance
  assert_flush_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !accept);

  // Output only appears after an emitting fetch
  assert_no_phantom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !emit |=> !out_valid);

endmodule

// File: tb/tb_qalign_buf.sv
module tb_qalign_buf;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [1:0]   in_offset = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_data;

  int errors = 0;
  int checks = 0;

  // Bench model
  logic         m_primed = 1'b0;
  logic [1:0]   m_off = '0;
  logic [127:0] m_old = '0;
  logic [127:0] m_q = '0;
  logic         m_cnt = 1'b0;

  always #10 clk = ~clk;

  qalign_buf dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_offset(in_offset),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [127:0] bmerge(input logic [127:0] o, input logic [127:0] n,
                                          input logic [1:0] k);
    logic [255:0] p;
    if (k == 2'd0) return n;
    p = {n, o} >> (32 * k);
    return p[127:0];
  endfunction

  function automatic logic [127:0] mkq(input logic [31:0] base);
    return {base + 32'd3, base + 32'd2, base + 32'd1, base};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, check, update model, wait next falling edge
  task automatic step(input logic v, input logic [127:0] d, input logic [1:0] o,
                      input logic rdy, input logic fl);
    logic exp_rdy;
    in_valid = v; in_data = d; in_offset = o; out_ready = rdy; flush = fl;
    #1;
    chk(out_valid == m_cnt, "R6 out_valid", 128'(out_valid), 128'(m_cnt));
    if (m_cnt && out_valid)
      chk(out_data == m_q, (m_off == 2'd0) ? "R5 out_data" : "R4 out_data", out_data, m_q);
    exp_rdy = !fl && (!m_cnt || rdy);
    chk(in_ready == exp_rdy, fl ? "R9 in_ready" : "R7 in_ready", 128'(in_ready), 128'(exp_rdy));
    if (fl) begin
      m_cnt = 1'b0;
      m_primed = 1'b0;
    end else begin
      if (m_cnt && rdy) m_cnt = 1'b0;
      if (v && exp_rdy) begin
        if (!m_primed) begin
          m_primed = 1'b1;
          m_off = o;
          if (o == 2'd0) begin m_q = d; m_cnt = 1'b1; end
        end else begin
          m_q = bmerge(m_old, d, m_off);
          m_cnt = 1'b1;
        end
        m_old = d;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", 128'(out_valid), 128'(0));
    chk(in_ready == 1'b1, "R1 in_ready", 128'(in_ready), 128'(1));
    rst_n = 1'b1;
    @(negedge clk);

    // R5 offset zero stream, first fetch passes through
    step(1'b1, mkq(32'h100), 2'd0, 1'b1, 1'b0);
    chk(out_valid && out_data == mkq(32'h100), "R5 first", out_data, mkq(32'h100));
    for (int i = 1; i < 4; i++) step(1'b1, mkq(32'h100 + 32'(i * 16)), 2'd0, 1'b1, 1'b0);

    // R9/R8 flush with a fetch offered
    step(1'b1, mkq(32'h999), 2'd3, 1'b1, 1'b1);
    chk(out_valid == 1'b0, "R8 after flush", 128'(out_valid), 128'(0));

    // R3 filling fetch, R4 offset 3 explicit values
    step(1'b1, mkq(32'h10), 2'd3, 1'b1, 1'b0);
    chk(out_valid == 1'b0, "R3 prime silent", 128'(out_valid), 128'(0));
    step(1'b1, mkq(32'h20), 2'd1, 1'b1, 1'b0);
    chk(out_data == {32'h22, 32'h21, 32'h20, 32'h13}, "R4 offset3",
        out_data, {32'h22, 32'h21, 32'h20, 32'h13});
    // R2 offset ignored mid-stream
    step(1'b1, mkq(32'h30), 2'd2, 1'b1, 1'b0);
    chk(out_data == {32'h32, 32'h31, 32'h30, 32'h23}, "R2 offset locked",
        out_data, {32'h32, 32'h31, 32'h30, 32'h23});

    // R7 stall with fetches offered
    for (int i = 0; i < 4; i++) step(1'b1, mkq(32'h40 + 32'(i)), 2'd0, 1'b0, 1'b0);
    chk(out_valid && out_data == {32'h32, 32'h31, 32'h30, 32'h23}, "R7 held",
        out_data, {32'h32, 32'h31, 32'h30, 32'h23});

    // R8 flush while holding, new stream offset 1
    step(1'b0, '0, 2'd0, 1'b0, 1'b1);
    step(1'b1, mkq(32'h50), 2'd1, 1'b1, 1'b0);
    chk(out_valid == 1'b0, "R8 reprime", 128'(out_valid), 128'(0));
    step(1'b1, mkq(32'h60), 2'd0, 1'b1, 1'b0);
    chk(out_data == {32'h60, 32'h53, 32'h52, 32'h51}, "R8 new offset",
        out_data, {32'h60, 32'h53, 32'h52, 32'h51});

    // Random mix, offset 2 burst included
    for (int i = 0; i < 4000; i++) begin
      logic [127:0] d;
      d = {$urandom, $urandom, $urandom, $urandom};
      step(($urandom % 4) != 0, d, 2'($urandom % 4), ($urandom % 3) != 0,
           ($urandom % 60) == 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule